// File: doc/BRIEF.md
# Parallel C/A Gold Code Generator

This block produces the 1023-chip coarse/acquisition spreading codes of 24 satellites at once for a GPS baseband correlator. Two 10-stage maximal-length shift registers run in lock step. Every satellite code is taken from the shared pair through its own two-tap select and an XOR. A single chip-rate enable moves all the codes forward together. The codes therefore keep a fixed alignment with each other, and a correlator bank can use any subset of them without a separate generator for each channel.

A small phase sequencer counts the chips of each period. It has three states. PH_FIRST holds chip 0, PH_MID covers chips 1 to 1021, and PH_LAST holds chip 1022. On an enabled chip the sequencer moves PH_FIRST to PH_MID. It moves PH_MID to PH_LAST when the count reaches 1021. It moves PH_LAST back to PH_FIRST and reloads both registers to all ones. While the sequencer is in PH_FIRST the epoch output is high, and that marks the code boundary for accumulators downstream. Consumers map a chip value of 0 to +1 and a chip value of 1 to -1.

Top module: `ca_code_bank`

## Requirements
- R1: After a clock edge with `rst` high, both registers hold all ones and the sequencer is in PH_FIRST. All 24 bits of `chips` then read 1 and `epoch` reads 1.
- R2: At a clock edge with `chip_en` low and `rst` low, `chips` and `epoch` keep their values.
- R3: The first register feeds back stage 3 XOR stage 10. The second feeds back the XOR of stages 2, 3, 6, 8, 9 and 10. On each enabled chip both registers shift from stage 1 toward stage 10, and the feedback bit enters stage 1.
- R4: `chips[k]` carries the code of satellite k+1. Its value is stage 10 of the first register XOR the two selected stages of the second register. The stage pairs for satellites 1..24 are (2,6) (3,7) (4,8) (5,9) (1,9) (2,10) (1,8) (2,9) (3,10) (2,3) (3,4) (5,6) (6,7) (7,8) (8,9) (9,10) (1,4) (2,5) (3,6) (4,7) (5,8) (6,9) (1,3) (4,6).
- R5: Read the first ten chips after reset first chip first, as a 10-bit number in octal. For satellites 1..24 these are 1440 1620 1710 1744 1133 1455 1131 1454 1626 1504 1642 1750 1764 1772 1775 1776 1156 1467 1633 1715 1746 1763 1063 1706.
- R6: `epoch` is high on chip 0 of every period and on no other chip. After 1023 enabled chips, every code has returned to its chip-0 value and the ten-chip prefix repeats.
- R7: Over one full period each satellite code holds exactly 512 ones.
- R8: `epoch` stays high through any number of idle cycles on chip 0. It falls after the first enabled chip.
- R9: `rst` takes priority over `chip_en`. A reset in the middle of a period restarts every code at chip 0.
- R10: The sequencer takes PH_FIRST to PH_MID to PH_LAST and back to PH_FIRST, one state change per enabled chip at the ends of the period. Both registers hold all ones whenever `epoch` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Chip-rate enable; one pulse advances every code by one chip |
| chips | output | NUM_SV | Current chip of each satellite code, bit k = satellite k+1 |
| epoch | output | 1 | High while the codes sit on chip 0 of the period |

## Verification
The bench reads the ten-chip prefixes of all 24 codes against the published octal values. A wrong tap pair or a wrong feedback tap shows up at once as a wrong prefix on the affected satellites. It runs one whole period and counts ones per code and epoch marks. An off-by-one period counter would put the epoch on the wrong chip or lose the 512-one balance, and a bad reload would break the repeat of the prefix. Idle gaps on chip 0 and a reset during a run catch a design that lets a code drift without an enable, pulses the epoch instead of holding it, or lets the enable win over reset.

// File: rtl/ca_code_pkg.sv
`timescale 1ns/1ps
package ca_code_pkg;

    localparam int CA_REG_W    = 10;
    localparam int CA_CODE_LEN = 1023;
    localparam int CA_MAX_SV   = 24;

    // stage n of a register lives in bit n-1
    localparam logic [CA_REG_W-1:0] G1_FB_MASK = 10'b10_0000_0100; // stages 3,10
    localparam logic [CA_REG_W-1:0] G2_FB_MASK = 10'b11_1010_0110; // stages 2,3,6,8,9,10

    typedef enum logic [1:0] {
        PH_FIRST = 2'd0,
        PH_MID   = 2'd1,
        PH_LAST  = 2'd2
    } ca_phase_e;

    // returns first_stage*16 + second_stage for satellite index sv (0-based)
    function automatic int ca_tap_pair(input int sv);
        int r;
        case (sv)
            0:  r = 2*16 + 6;
            1:  r = 3*16 + 7;
            2:  r = 4*16 + 8;
            3:  r = 5*16 + 9;
            4:  r = 1*16 + 9;
            5:  r = 2*16 + 10;
            6:  r = 1*16 + 8;
            7:  r = 2*16 + 9;
            8:  r = 3*16 + 10;
            9:  r = 2*16 + 3;
            10: r = 3*16 + 4;
            11: r = 5*16 + 6;
            12: r = 6*16 + 7;
            13: r = 7*16 + 8;
            14: r = 8*16 + 9;
            15: r = 9*16 + 10;
            16: r = 1*16 + 4;
            17: r = 2*16 + 5;
            18: r = 3*16 + 6;
            19: r = 4*16 + 7;
            20: r = 5*16 + 8;
            21: r = 6*16 + 9;
            22: r = 1*16 + 3;
            default: r = 4*16 + 6;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ca_lfsr.sv
`timescale 1ns/1ps
module ca_lfsr #(
    parameter int                REG_W   = 10,
    parameter logic [REG_W-1:0]  FB_MASK = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             reload,
    output logic [REG_W-1:0] state_q
);

    logic feedback;

    always_comb begin
        feedback = ^(state_q & FB_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            state_q <= '1;
        end else if (step) begin
            state_q <= {state_q[REG_W-2:0], feedback};
        end
    end

endmodule

// File: rtl/ca_phase_seq.sv
`timescale 1ns/1ps
module ca_phase_seq
    import ca_code_pkg::*;
#(
    parameter int CODE_LEN = 1023,
    localparam int CNT_W   = $clog2(CODE_LEN)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      chip_en,
    output ca_phase_e phase,
    output logic      reload,
    output logic      at_first
);

    localparam logic [CNT_W-1:0] MID_END = CNT_W'(CODE_LEN - 2);

    ca_phase_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (chip_en) begin
            unique case (state_q)
                PH_FIRST: begin
                    state_d = PH_MID;
                    cnt_d   = CNT_W'(1);
                end
                PH_MID: begin
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_q == MID_END) begin
                        state_d = PH_LAST;
                    end
                end
                PH_LAST: begin
                    state_d = PH_FIRST;
                    cnt_d   = '0;
                end
                default: begin
                    state_d = PH_FIRST;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_FIRST;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        phase    = state_q;
        reload   = chip_en && (state_q == PH_LAST);
        at_first = (state_q == PH_FIRST);
    end

endmodule

// File: rtl/ca_tap_combine.sv
`timescale 1ns/1ps
module ca_tap_combine
    import ca_code_pkg::*;
#(
    parameter int NUM_SV = 24,
    parameter int REG_W  = 10
) (
    input  logic              g1_out,
    input  logic [REG_W-1:0]  g2_state,
    output logic [NUM_SV-1:0] chips
);

    for (genvar sv = 0; sv < NUM_SV; sv++) begin : g_sv
        localparam int PAIR  = ca_tap_pair(sv);
        localparam int TAP_A = PAIR / 16 - 1;
        localparam int TAP_B = PAIR % 16 - 1;
        assign chips[sv] = g1_out ^ g2_state[TAP_A] ^ g2_state[TAP_B];
    end

endmodule

// File: rtl/ca_code_bank.sv
`timescale 1ns/1ps
module ca_code_bank
    import ca_code_pkg::*;
#(
    parameter int NUM_SV   = 24,
    parameter int CODE_LEN = CA_CODE_LEN,
    parameter int REG_W    = CA_REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    output logic [NUM_SV-1:0] chips,
    output logic              epoch
);

    ca_phase_e        phase;
    logic             reload;
    logic             at_first;
    logic [REG_W-1:0] g1_q;
    logic [REG_W-1:0] g2_q;

    ca_phase_seq #(.CODE_LEN(CODE_LEN)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .chip_en  (chip_en),
        .phase    (phase),
        .reload   (reload),
        .at_first (at_first)
    );

    ca_lfsr #(.REG_W(REG_W), .FB_MASK(G1_FB_MASK)) u_g1 (
        .clk     (clk),
        .rst     (rst),
        .step    (chip_en),
        .reload  (reload),
        .state_q (g1_q)
    );

    ca_lfsr #(.REG_W(REG_W), .FB_MASK(G2_FB_MASK)) u_g2 (
        .clk     (clk),
        .rst     (rst),
        .step    (chip_en),
        .reload  (reload),
        .state_q (g2_q)
    );

    ca_tap_combine #(.NUM_SV(NUM_SV), .REG_W(REG_W)) u_comb (
        .g1_out   (g1_q[REG_W-1]),
        .g2_state (g2_q),
        .chips    (chips)
    );

    assign epoch = at_first;

endmodule

// File: rtl/ca_code_bank_chk.sv
`timescale 1ns/1ps
module ca_code_bank_chk
    import ca_code_pkg::*;
#(
    parameter int NUM_SV = 24,
    parameter int REG_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              chip_en,
    input logic [NUM_SV-1:0] chips,
    input logic              epoch,
    input logic [REG_W-1:0]  g1_q,
    input logic [REG_W-1:0]  g2_q,
    input ca_phase_e         phase
);

    AST_RESET_LOADS: assert property (@(posedge clk) rst |=> (epoch && (&chips))); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !chip_en |=> ($stable(chips) && $stable(epoch))); // R2
    AST_EPOCH_ALL_ONES: assert property (@(posedge clk) disable iff (rst) epoch |-> ((&g1_q) && (&g2_q))); // R10
    AST_LAST_WRAPS: assert property (@(posedge clk) disable iff (rst) (phase == PH_LAST && chip_en) |=> epoch); // R6
    AST_FIRST_LEAVES: assert property (@(posedge clk) disable iff (rst) (epoch && chip_en) |=> (!epoch && phase == PH_MID)); // R8
    AST_REGS_NONZERO: assert property (@(posedge clk) disable iff (rst) (g1_q != '0) && (g2_q != '0)); // R3

endmodule

bind ca_code_bank ca_code_bank_chk #(.NUM_SV(NUM_SV), .REG_W(REG_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .chip_en (chip_en),
    .chips   (chips),
    .epoch   (epoch),
    .g1_q    (g1_q),
    .g2_q    (g2_q),
    .phase   (phase)
);

// File: tb/ca_code_bank_tb.sv
`timescale 1ns/1ps
module ca_code_bank_tb;

    localparam int NSV  = 24;
    localparam int PLEN = 1023;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           chip_en = 1'b0;
    logic [NSV-1:0] chips;
    logic           epoch;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    ca_code_bank u_dut (
        .clk     (clk),
        .rst     (rst),
        .chip_en (chip_en),
        .chips   (chips),
        .epoch   (epoch)
    );

    // R5: published ten-chip prefixes, octal, first chip in the MSB
    function automatic logic [9:0] prefix_of(input int sv);
        logic [9:0] p;
        case (sv)
            0:  p = 10'o1440;  1:  p = 10'o1620;  2:  p = 10'o1710;  3:  p = 10'o1744;
            4:  p = 10'o1133;  5:  p = 10'o1455;  6:  p = 10'o1131;  7:  p = 10'o1454;
            8:  p = 10'o1626;  9:  p = 10'o1504;  10: p = 10'o1642;  11: p = 10'o1750;
            12: p = 10'o1764;  13: p = 10'o1772;  14: p = 10'o1775;  15: p = 10'o1776;
            16: p = 10'o1156;  17: p = 10'o1467;  18: p = 10'o1633;  19: p = 10'o1715;
            20: p = 10'o1746;  21: p = 10'o1763;  22: p = 10'o1063;  default: p = 10'o1706;
        endcase
        return p;
    endfunction

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        chip_en = 1'b0;
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    // collects the next ten chips (chip_en held high) and checks each prefix
    task automatic check_prefixes(input string req);
        logic [9:0] cap [NSV];
        chip_en = 1'b1;
        for (int k = 0; k < 10; k++) begin
            for (int s = 0; s < NSV; s++) cap[s][9-k] = chips[s];
            tick();
        end
        chip_en = 1'b0;
        for (int s = 0; s < NSV; s++)
            check(cap[s] == prefix_of(s), req, int'(cap[s]), int'(prefix_of(s)));
    endtask

    task automatic t_reset_state();
        do_reset();
        check(chips == '1, "R1 chips", int'(chips), int'({NSV{1'b1}}));
        check(epoch == 1'b1, "R1 epoch", int'(epoch), 1);
    endtask

    task automatic t_prefixes();
        do_reset();
        check_prefixes("R5/R4/R3 prefix");
    endtask

    task automatic t_idle_hold();
        logic [NSV-1:0] held;
        do_reset();
        chip_en = 1'b1;
        tick(); tick(); tick();
        chip_en = 1'b0;
        held = chips;
        for (int k = 0; k < 6; k++) tick();
        check(chips == held, "R2 chips hold", int'(chips), int'(held));
        check(epoch == 1'b0, "R2 epoch hold", int'(epoch), 0);
    endtask

    task automatic t_epoch_level();
        do_reset();
        for (int k = 0; k < 5; k++) tick();
        check(epoch == 1'b1, "R8 epoch held idle", int'(epoch), 1);
        chip_en = 1'b1;
        tick();
        chip_en = 1'b0;
        check(epoch == 1'b0, "R8 epoch falls", int'(epoch), 0);
    endtask

    task automatic t_full_period();
        int ones [NSV];
        int epochs;
        int bad_pos;
        do_reset();
        epochs  = 0;
        bad_pos = 0;
        for (int s = 0; s < NSV; s++) ones[s] = 0;
        chip_en = 1'b1;
        for (int k = 0; k < PLEN; k++) begin
            for (int s = 0; s < NSV; s++) ones[s] += int'(chips[s]);
            if (epoch) epochs++;
            if (epoch != (k == 0)) bad_pos++;
            tick();
        end
        chip_en = 1'b0;
        check(epochs == 1, "R6 epoch count", epochs, 1);
        check(bad_pos == 0, "R6 epoch position", bad_pos, 0);
        check(epoch == 1'b1, "R6 epoch at wrap", int'(epoch), 1);
        check(chips == '1, "R6 chips at wrap", int'(chips), int'({NSV{1'b1}}));
        for (int s = 0; s < NSV; s++)
            check(ones[s] == 512, "R7 balance", ones[s], 512);
        check_prefixes("R6 prefix repeat");
    endtask

    task automatic t_mid_reset();
        do_reset();
        chip_en = 1'b1;
        for (int k = 0; k < 300; k++) tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chip_en = 1'b0;
        check(chips == '1, "R9 chips after reset", int'(chips), int'({NSV{1'b1}}));
        check(epoch == 1'b1, "R9 epoch after reset", int'(epoch), 1);
        check_prefixes("R9 prefix after reset");
    endtask

    task automatic t_sequence_ends();
        // R10: walk to chip 1022, see no epoch, then wrap onto epoch
        do_reset();
        chip_en = 1'b1;
        for (int k = 0; k < PLEN - 1; k++) tick();
        chip_en = 1'b0;
        check(epoch == 1'b0, "R10 last chip no epoch", int'(epoch), 0);
        chip_en = 1'b1;
        tick();
        chip_en = 1'b0;
        check(epoch == 1'b1, "R10 wrap to first", int'(epoch), 1);
    endtask

    initial begin
        tick();
        t_reset_state();
        t_prefixes();
        t_idle_hold();
        t_epoch_level();
        t_full_period();
        t_mid_reset();
        t_sequence_ends();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule